// File: doc/BRIEF.md
# Block-Input Transfer Sequencer

This block runs the execution phase of a CPU's block-input instructions. A decode stage hands it several values in one cycle on `start_i`:

- the second opcode byte;
- whether an address-mode prefix came before the opcode, and which mode that prefix selects;
- the current long/short mode;
- the register values BC, DE, HL, the upper I/O byte and the flag byte.

The sequencer then runs a loop of transfers over a simple request/acknowledge bus. In each transfer it reads one byte from an I/O address and then writes that byte to the memory location held in HL.

After each transfer it steps the count, pointer and address registers as the selected variant requires. When the loop ends, it pulses `done_o` for one cycle. In that cycle the outputs carry the updated registers, the resulting flags and the architectural cycle count of the instruction. The decode stage copies these values back into its register file.

There are five variants. Two are single transfers: one steps HL only, and the other also increments C. The other three repeat. One counts down on the 8-bit B with HL moving downward. One counts down on the 16-bit BC from a fixed I/O address held in DE. One counts down on BC while DE and HL both move upward.

Top module: `blkin_seq`

## Requirements
- R1: `start_i` is accepted while idle only for opcode byte 0xA2 (single), 0x84 (dual), 0xBA (repeat-down), 0xCA (stationary) or 0x94 (repeat-up). Any other value produces no bus request and no `done_o`.
- R2: Each transfer is an I/O read (`bus_we_o`=0, `bus_io_o`=1), followed by a memory write (`bus_we_o`=1, `bus_io_o`=0) to the address HL, carrying the byte just read. A transfer never starts with a write.
- R3: The low 16 bits of the I/O address come from BC for 0xA2, 0x84 and 0xBA, and from DE for 0xCA and 0x94. The upper byte is 0 for 0x94 and the supplied upper I/O byte otherwise.
- R4: The registers change as follows after each transfer:

  | Opcode | Count | HL | Other |
  |---|---|---|---|
  | 0xA2 | B−1 | +1 | — |
  | 0x84 | B−1 | +1 | C+1 |
  | 0xBA | B−1 | −1 | — |
  | 0xCA | BC−1 | −1 | DE unchanged |
  | 0x94 | BC−1 | +1 | DE+1 |

- R5: 0xBA repeats until B reaches zero. 0xCA and 0x94 repeat until BC reaches zero. An initial B of 0 gives 256 transfers, and an initial BC of 0 gives 65536 transfers.
- R6: In the result flags, bit 6 (Z) is set exactly when the count is zero after the last decrement. Bit 1 (N) equals bit 7 of the last byte transferred. Bits 7, 5, 4, 3, 2 and 0 keep their input values.
- R7: In long mode HL steps as a 24-bit value with wrap. In short mode only HL[15:0] steps, with 16-bit wrap, and HL[23:16] is kept. The mode comes from `pfx_long_i` when `pfx_valid_i` is high, and from `adl_i` otherwise.
- R8: `cycles_o` reports 2 + 3·transfers for the repeating variants and 5 for the single ones. One more cycle is added when `pfx_valid_i` was high.
- R9: While `bus_req_o` is high and `bus_ack_i` is low, the bus address, the direction and the write data hold their values.
- R10: `done_o` pulses for exactly one cycle after the acknowledge of the last write. `busy_o` is high from the cycle after acceptance through the `done_o` cycle. A `start_i` pulse, or a change of the operand inputs, while busy has no effect on the result.
- R11: During reset, `busy_o`, `done_o` and `bus_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| opcode_i | input | 8 | Second opcode byte |
| pfx_valid_i | input | 1 | An address-mode prefix preceded the opcode |
| pfx_long_i | input | 1 | Prefix selects long mode (1) or short mode (0) |
| adl_i | input | 1 | Current mode when no prefix is present (1 = long) |
| bc_i | input | 16 | BC register |
| de_i | input | 16 | DE register |
| hl_i | input | 24 | HL pointer |
| uu_i | input | 8 | Upper I/O address byte |
| flags_i | input | 8 | Flag byte |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_io_o | output | 1 | 1 = I/O space, 0 = memory space |
| bus_addr_o | output | 24 | Bus address |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Transaction acknowledge |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| bc_o | output | 16 | Resulting BC |
| de_o | output | 16 | Resulting DE |
| hl_o | output | 24 | Resulting HL |
| flags_o | output | 8 | Resulting flags |
| cycles_o | output | 18 | Architectural cycle count |

## Verification
Three things happen on the same clock edge: the acknowledge of a write, the register update, and the decision whether to loop or finish. The dangerous case is a count reaching zero on that edge. The bench provokes it with acknowledges that arrive with no wait and with several wait cycles, and with counts of 1 and of 0 (the 256-transfer case). It judges the result by requiring an exact match of the whole expected transaction list: an extra read after the final write, or a missing one, is reported. A second `start_i` pulse with changed operands is placed in the middle of a run, and the results must still match the first instruction alone.

// File: rtl/blkin_pkg.sv
package blkin_pkg;
  localparam logic [7:0] OP_SINGLE = 8'hA2;
  localparam logic [7:0] OP_DUAL   = 8'h84;
  localparam logic [7:0] OP_REPDN  = 8'hBA;
  localparam logic [7:0] OP_STAT   = 8'hCA;
  localparam logic [7:0] OP_REPUP  = 8'h94;

  localparam int Z_BIT = 6;
  localparam int N_BIT = 1;

  typedef struct packed {
    logic valid;
    logic rep;     // repeating variant
    logic cnt16;   // count is BC instead of B
    logic io_de;   // I/O address low half from DE
    logic io_up0;  // force upper I/O byte to zero
    logic hl_dn;   // HL steps downward
    logic c_inc;   // increment C
    logic de_inc;  // increment DE
  } attr_t;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FIN} st_e;
endpackage

// File: rtl/blkin_decode.sv
module blkin_decode
  import blkin_pkg::*;
(
  input  logic [7:0] op_i,
  output attr_t      attr_o
);
  always_comb begin
    attr_o = '0;
    unique case (op_i)
      OP_SINGLE: begin attr_o.valid = 1'b1; end
      OP_DUAL:   begin attr_o.valid = 1'b1; attr_o.c_inc = 1'b1; end
      OP_REPDN:  begin attr_o.valid = 1'b1; attr_o.rep = 1'b1; attr_o.hl_dn = 1'b1; end
      OP_STAT: begin
        attr_o.valid = 1'b1; attr_o.rep = 1'b1; attr_o.cnt16 = 1'b1;
        attr_o.io_de = 1'b1; attr_o.hl_dn = 1'b1;
      end
      OP_REPUP: begin
        attr_o.valid = 1'b1; attr_o.rep = 1'b1; attr_o.cnt16 = 1'b1;
        attr_o.io_de = 1'b1; attr_o.io_up0 = 1'b1; attr_o.de_inc = 1'b1;
      end
      default: attr_o = '0;
    endcase
  end
endmodule

// File: rtl/blkin_ptr_step.sv
module blkin_ptr_step #(
  parameter int W     = 24,
  parameter int LOW_W = 16
) (
  input  logic [W-1:0] ptr_i,
  input  logic         long_i,
  input  logic         down_i,
  output logic [W-1:0] ptr_o
);
  logic [W-1:0]     full_nx;
  logic [LOW_W-1:0] low_nx;

  always_comb begin
    full_nx = down_i ? ptr_i - W'(1) : ptr_i + W'(1);
    low_nx  = down_i ? ptr_i[LOW_W-1:0] - LOW_W'(1) : ptr_i[LOW_W-1:0] + LOW_W'(1);
  end

  generate
    if (LOW_W < W) begin : g_split
      assign ptr_o = long_i ? full_nx : {ptr_i[W-1:LOW_W], low_nx};
    end else begin : g_flat
      assign ptr_o = full_nx;
    end
  endgenerate
endmodule

// File: rtl/blkin_cnt_step.sv
module blkin_cnt_step #(
  parameter int W      = 16,
  parameter int NARROW = 8
) (
  input  logic [W-1:0] cnt_i,
  input  logic         wide_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  localparam int LO_W = W - NARROW;

  logic [W-1:0]      wide_nx;
  logic [NARROW-1:0] hi_nx;

  always_comb begin
    wide_nx = cnt_i - W'(1);
    hi_nx   = cnt_i[W-1:LO_W] - NARROW'(1);
    if (wide_i) begin
      cnt_o  = wide_nx;
      zero_o = (wide_nx == '0);
    end else begin
      cnt_o  = {hi_nx, cnt_i[LO_W-1:0]};
      zero_o = (hi_nx == '0);
    end
  end
endmodule

// File: rtl/blkin_cyc_acc.sv
module blkin_cyc_acc #(
  parameter int W    = 18,
  parameter int STEP = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         add_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (add_i)  cnt_o <= cnt_o + W'(STEP);
  end
endmodule

// File: rtl/blkin_seq.sv
module blkin_seq
  import blkin_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IO_W   = 16,
  parameter int DATA_W = 8,
  parameter int CYC_W  = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic              pfx_valid_i,
  input  logic              pfx_long_i,
  input  logic              adl_i,
  input  logic [IO_W-1:0]   bc_i,
  input  logic [IO_W-1:0]   de_i,
  input  logic [ADDR_W-1:0] hl_i,
  input  logic [7:0]        uu_i,
  input  logic [7:0]        flags_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic              bus_io_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [IO_W-1:0]   bc_o,
  output logic [IO_W-1:0]   de_o,
  output logic [ADDR_W-1:0] hl_o,
  output logic [7:0]        flags_o,
  output logic [CYC_W-1:0]  cycles_o
);
  localparam int UP_W = ADDR_W - IO_W;
  localparam int C_W  = IO_W / 2;
  localparam logic [CYC_W-1:0] BASE_REP = CYC_W'(2);
  localparam logic [CYC_W-1:0] BASE_ONE = CYC_W'(5);

  st_e   state_q;
  attr_t attr_d, attr_q;
  logic  long_q;
  logic [IO_W-1:0]   bc_q, de_q, bc_nx, bc_upd, de_nx;
  logic [ADDR_W-1:0] hl_q, hl_nx, io_addr;
  logic [7:0]        uu_q, fl_q, fl_nx;
  logic [DATA_W-1:0] data_q;
  logic              cnt_zero, accept, mode_long, wr_done, last;
  logic [CYC_W-1:0]  cyc_base;
  logic              io_up0_w;

  blkin_decode u_dec (.op_i(opcode_i), .attr_o(attr_d));

  blkin_cnt_step #(.W(IO_W), .NARROW(IO_W - C_W)) u_cnt (
    .cnt_i(bc_q), .wide_i(attr_q.cnt16), .cnt_o(bc_nx), .zero_o(cnt_zero)
  );

  blkin_ptr_step #(.W(ADDR_W), .LOW_W(IO_W)) u_hl (
    .ptr_i(hl_q), .long_i(long_q), .down_i(attr_q.hl_dn), .ptr_o(hl_nx)
  );

  assign mode_long = pfx_valid_i ? pfx_long_i : adl_i;
  assign accept    = (state_q == S_IDLE) && start_i && attr_d.valid;
  assign wr_done   = (state_q == S_WR) && bus_ack_i;
  assign last      = !attr_q.rep || cnt_zero;
  assign io_up0_w  = attr_q.io_up0;

  always_comb begin
    bc_upd = bc_nx;
    if (attr_q.c_inc) bc_upd[C_W-1:0] = bc_q[C_W-1:0] + C_W'(1);
    de_nx = attr_q.de_inc ? de_q + IO_W'(1) : de_q;
    fl_nx = fl_q;
    fl_nx[Z_BIT] = cnt_zero;
    fl_nx[N_BIT] = data_q[DATA_W-1];
    io_addr = {(attr_q.io_up0 ? UP_W'(0) : UP_W'(uu_q)),
               (attr_q.io_de ? de_q : bc_q)};
    cyc_base = (attr_d.rep ? BASE_REP : BASE_ONE) + CYC_W'(pfx_valid_i);
  end

  blkin_cyc_acc #(.W(CYC_W), .STEP(3)) u_cyc (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept), .load_val_i(cyc_base),
    .add_i(wr_done && attr_q.rep), .cnt_o(cycles_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      attr_q  <= '0;
      long_q  <= 1'b0;
      bc_q    <= '0;
      de_q    <= '0;
      hl_q    <= '0;
      uu_q    <= '0;
      fl_q    <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          attr_q  <= attr_d;
          long_q  <= mode_long;
          bc_q    <= bc_i;
          de_q    <= de_i;
          hl_q    <= hl_i;
          uu_q    <= uu_i;
          fl_q    <= flags_i;
          state_q <= S_RD;
        end
        S_RD: if (bus_ack_i) begin
          data_q  <= bus_rdata_i;
          state_q <= S_WR;
        end
        S_WR: if (bus_ack_i) begin
          bc_q    <= bc_upd;
          de_q    <= de_nx;
          hl_q    <= hl_nx;
          fl_q    <= fl_nx;
          state_q <= last ? S_FIN : S_RD;
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign bus_req_o   = (state_q == S_RD) || (state_q == S_WR);
  assign bus_we_o    = (state_q == S_WR);
  assign bus_io_o    = (state_q == S_RD);
  assign bus_addr_o  = (state_q == S_RD) ? io_addr : hl_q;
  assign bus_wdata_o = data_q;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_FIN);
  assign bc_o        = bc_q;
  assign de_o        = de_q;
  assign hl_o        = hl_q;
  assign flags_o     = fl_q;
endmodule

// File: rtl/blkin_seq_chk.sv
module blkin_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              up0_i
);
  // R9
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) &&
                                   $stable(bus_we_o) && $stable(bus_wdata_o)));
  // R2
  read_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> !bus_we_o);
  // R2
  write_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_we_o && bus_ack_i) |=> (bus_req_o && bus_we_o));
  // R3
  io_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_we_o && up0_i) |-> (bus_addr_o[ADDR_W-1:16] == '0));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!bus_req_o && busy_o));
  // R10
  req_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o);
endmodule

bind blkin_seq blkin_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
  .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i),
  .busy_o(busy_o), .done_o(done_o), .up0_i(io_up0_w)
);

// File: tb/blkin_seq_test.sv
module blkin_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        pfx_v = 1'b0, pfx_l = 1'b0, adl = 1'b0;
  logic [15:0] bc = '0, de = '0;
  logic [23:0] hl = '0;
  logic [7:0]  uu = '0, fl = '0;
  logic        bus_req, bus_we, bus_io, bus_ack = 1'b0;
  logic [23:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata = '0;
  logic        busy, done;
  logic [15:0] bc_o, de_o;
  logic [23:0] hl_o;
  logic [7:0]  fl_o;
  logic [17:0] cyc_o;

  blkin_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .pfx_valid_i(pfx_v), .pfx_long_i(pfx_l), .adl_i(adl), .bc_i(bc), .de_i(de),
    .hl_i(hl), .uu_i(uu), .flags_i(fl), .bus_req_o(bus_req), .bus_we_o(bus_we),
    .bus_io_o(bus_io), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack), .busy_o(busy), .done_o(done),
    .bc_o(bc_o), .de_o(de_o), .hl_o(hl_o), .flags_o(fl_o), .cycles_o(cyc_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic        we;
    logic [23:0] addr;
    logic [23:0] mask;
    logic [7:0]  data;
  } txn_t;
  typedef struct {
    logic [15:0] bc, de;
    logic [23:0] hl;
    logic [7:0]  fl;
    logic [17:0] cyc;
  } res_t;

  txn_t txn_q[$];
  res_t res_q[$];
  int checks = 0, errors = 0;
  int lat = 0, wait_cnt = 0, dseed = 1, cycle_no = 0;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycle_no++;
    if (cycle_no > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cycle_no);
      finish_run();
    end
  end

  // Bus responder and transaction monitor
  always @(negedge clk) begin
    if (bus_ack) begin
      bus_ack = 1'b0;
      wait_cnt = lat;
    end else if (rst_n && bus_req) begin
      if (wait_cnt > 0) wait_cnt--;
      else begin
        checks++;
        if (txn_q.size() == 0) begin
          errors++;
          $display("FAIL R2: unexpected txn we=%b addr=%h, expected none", bus_we, bus_addr);
        end else begin
          txn_t t;
          t = txn_q.pop_front();
          if (bus_we !== t.we || bus_io !== ~t.we ||
              (bus_addr & t.mask) !== (t.addr & t.mask) ||
              (t.we && bus_wdata !== t.data)) begin
            errors++;
            $display("FAIL R2/R3/R9: txn we=%b io=%b addr=%h data=%h expected we=%b addr=%h(mask %h) data=%h",
                     bus_we, bus_io, bus_addr, bus_wdata, t.we, t.addr, t.mask, t.data);
          end
          if (!t.we) bus_rdata = t.data;
        end
        bus_ack = 1'b1;
      end
    end
  end

  // Result monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (res_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: unexpected done, expected none");
      end else begin
        res_t r;
        r = res_q.pop_front();
        checks += 3;
        if (bc_o !== r.bc || de_o !== r.de || hl_o !== r.hl) begin
          errors++;
          $display("FAIL R4/R5/R7: bc=%h de=%h hl=%h expected bc=%h de=%h hl=%h",
                   bc_o, de_o, hl_o, r.bc, r.de, r.hl);
        end
        if (fl_o !== r.fl) begin
          errors++;
          $display("FAIL R6: flags=%h expected %h", fl_o, r.fl);
        end
        if (cyc_o !== r.cyc) begin
          errors++;
          $display("FAIL R8: cycles=%0d expected %0d", cyc_o, r.cyc);
        end
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Driver: model the instruction, push expectations, then launch it
  task automatic run(input logic [7:0] op, input bit pv, input bit pl, input bit ad,
                     input logic [15:0] b, input logic [15:0] d, input logic [23:0] h,
                     input logic [7:0] u, input logic [7:0] f, input int l, input bit poke);
    bit rep = (op == 8'hBA) || (op == 8'hCA) || (op == 8'h94);
    bit c16 = (op == 8'hCA) || (op == 8'h94);
    bit lng = pv ? pl : ad;
    bit dn  = (op == 8'hBA) || (op == 8'hCA);
    logic [15:0] mb = b, md = d;
    logic [23:0] mh = h;
    logic [7:0]  dat = '0;
    bit z;
    int iters = 0;
    txn_t t;
    res_t r;
    do begin
      t.we = 1'b0;
      t.addr = {(op == 8'h94) ? 8'h00 : u, c16 ? md : mb};
      t.mask = (op == 8'h94) ? 24'hFFFFFF : 24'h00FFFF;
      dat = 8'(dseed * 37 + 11);
      dseed++;
      t.data = dat;
      txn_q.push_back(t);
      t.we = 1'b1; t.addr = mh; t.mask = 24'hFFFFFF; t.data = dat;
      txn_q.push_back(t);
      if (c16) begin mb = mb - 16'd1; z = (mb == 16'd0); end
      else begin mb[15:8] = mb[15:8] - 8'd1; z = (mb[15:8] == 8'd0); end
      if (op == 8'h84) mb[7:0] = mb[7:0] + 8'd1;
      if (op == 8'h94) md = md + 16'd1;
      if (lng) mh = dn ? mh - 24'd1 : mh + 24'd1;
      else mh[15:0] = dn ? mh[15:0] - 16'd1 : mh[15:0] + 16'd1;
      iters++;
    end while (rep && !z);
    r.bc = mb; r.de = md; r.hl = mh;
    r.fl = (f & 8'hBD) | {1'b0, z, 4'b0, dat[7], 1'b0};
    r.cyc = 18'((rep ? 2 + 3 * iters : 5) + (pv ? 1 : 0));
    res_q.push_back(r);

    @(negedge clk);
    lat = l; wait_cnt = l;
    opcode = op; pfx_v = pv; pfx_l = pl; adl = ad;
    bc = b; de = d; hl = h; uu = u; fl = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R10 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      opcode = 8'hA2; bc = 16'h0101; de = 16'h7777; hl = 24'h000000; fl = 8'h00;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (res_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R10 idle after done", int'({busy, done}), 0);
    check(txn_q.size() == 0, "R2 pending txns after done", txn_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(busy === 1'b0 && done === 1'b0 && bus_req === 1'b0, "R11 reset outputs",
          int'({busy, done, bus_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4 R7: single, long mode, HL carries into upper byte
    run(8'hA2, 0, 0, 1, 16'h0510, 16'h0000, 24'h12FFFF, 8'h3C, 8'hFF, 0, 0);
    // R4 R6 R7 R8: dual, short prefix, HL low wrap, C wrap, Z set
    run(8'h84, 1, 0, 1, 16'h01FF, 16'h0000, 24'h40FFFF, 8'h11, 8'h00, 1, 0);
    // R5 R3 R9: repeat-down, B=3, slow acknowledge
    run(8'hBA, 0, 0, 1, 16'h03A5, 16'h9999, 24'h200002, 8'h22, 8'hA5, 2, 0);
    // R3 R4 R7: stationary, long prefix over short mode, HL underflow
    run(8'hCA, 1, 1, 0, 16'h0004, 16'h1234, 24'h000001, 8'h33, 8'h5A, 0, 0);
    // R3 R4 R7: repeat-up, short mode, DE and HL wrap
    run(8'h94, 0, 0, 0, 16'h0005, 16'hFFFE, 24'h55FFFE, 8'h44, 8'h81, 1, 0);
    // R5 R8: B=0 gives 256 transfers
    run(8'hBA, 0, 0, 1, 16'h0000, 16'h0000, 24'h300000, 8'h55, 8'h00, 0, 0);
    // R5 boundary: BC=1 single pass of a 16-bit repeat
    run(8'hCA, 0, 0, 1, 16'h0001, 16'h00FE, 24'h000010, 8'h66, 8'hFF, 0, 0);
    // R10: start while busy is ignored
    run(8'h94, 1, 0, 1, 16'h0006, 16'h0100, 24'h001000, 8'h77, 8'h24, 1, 1);

    // R1: unknown opcode ignored
    @(negedge clk);
    opcode = 8'hB2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      bit seen = 0;
      for (int i = 0; i < 20; i++) begin
        if (busy || bus_req || done) seen = 1;
        @(negedge clk);
      end
      check(!seen, "R1 unknown opcode activity", int'(seen), 0);
    end

    finish_run();
  end
endmodule